// File: doc/BRIEF.md
# Clock Lane Burst Controller

This block sequences a single unidirectional clock lane between its low-power line states and high-speed clock transmission. From the Stop state (both lines high) a start request walks the lane through the high-speed request pattern. The lane then holds HS-0 for a programmable lead-in and toggles the HS state once per clock cycle, which forms the DDR clock. After a stop request the lane holds HS-0 for a programmable trailer and returns to Stop. Every burst begins and ends on HS-0 and has an even number of HS transitions.

The same controller owns the ultra-low-power state. A ULPS request from Stop drives Mark-1 (LP-10), then parks the lines at Space (LP-00). A wake request drives Mark-1 for a parameterised wake-up time and then returns to Stop. All timed steps count a shared `tick` enable, so the caller chooses the time base, for example one tick per microsecond. Requests that do not fit the current phase are dropped, and `busy` tells the caller when a sequence is running.

States: `ST_STOP` (LP-11), `ST_HS_REQ` (LP-01), `ST_HS_BRIDGE` (LP-00, driver off), `ST_HS_LEAD` (HS-0), `ST_HS_CLK` (toggling), `ST_HS_TRAIL` (HS-0), `ST_ULPS_REQ` (LP-10), `ST_ULPS` (LP-00), `ST_WAKE` (LP-10). Transitions:
- STOP→HS_REQ on start.
- STOP→ULPS_REQ on ULPS request. Start wins if both arrive together.
- HS_REQ→HS_BRIDGE→HS_LEAD→HS_CLK, each on timer expiry.
- HS_CLK→HS_TRAIL when a latched stop meets an HS-1 half-cycle.
- HS_TRAIL→STOP on expiry.
- ULPS_REQ→ULPS on expiry.
- ULPS→WAKE on wake.
- WAKE→STOP on expiry.

Top module: `clk_lane_ctrl`

## Requirements
- R1: After reset the lane is in Stop: `lp_p`=1, `lp_n`=1, `hs_drive_en`=0, `hs_level`=0, `busy`=0.
- R2: A one-cycle `start_req` in Stop gives LP-01 (`lp_p`=0, `lp_n`=1) for LP_STEP_TICKS+1 cycles. It is followed by LP-00 with `hs_drive_en`=0 for LP_STEP_TICKS+1 cycles, and then `hs_drive_en` rises. These counts assume `tick` high every cycle. While `hs_drive_en`=1 the LP lines are both 0.
- R3: Once `hs_drive_en` rises, `hs_level` stays 0 for exactly LEAD_TICKS+2 cycles before the first 1 (with `tick` high every cycle).
- R4: During toggling, `hs_level` inverts every clock cycle. A `stop_req` is acted on only after the current HS-1 half-cycle ends. The burst therefore ends with `hs_level`=0 and has an even, non-zero number of transitions.
- R5: After the last falling transition, HS-0 holds for TRAIL_TICKS+1 cycles. Then `hs_drive_en` falls and the lines return to LP-11.
- R6: A one-cycle `ulps_req` in Stop gives LP-10 for LP_STEP_TICKS+1 cycles, then LP-00 held indefinitely until a wake request.
- R7: A `wake_req` in ULPS gives LP-10 for WAKE_TICKS+1 cycles and then LP-11 (Stop).
- R8: The following requests are ignored and leave the lines unchanged:
  - `wake_req` and `stop_req` in Stop;
  - `start_req` and `ulps_req` in ULPS;
  - `start_req` and `ulps_req` while an entry or exit sequence is running.
- R9: `busy` is 0 in Stop, in ULPS, and while toggling before a stop has been taken. It is 1 in every other phase.
- R10: Timed phases advance only on cycles with `tick`=1. With `tick` held at 0 the lane stays in its current LP state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable for all timed phases |
| start_req | input | 1 | Request an HS clock burst |
| stop_req | input | 1 | Request end of the running burst |
| ulps_req | input | 1 | Request ultra-low-power entry |
| wake_req | input | 1 | Request wake-up from ULPS |
| lp_p | output | 1 | Low-power level of the positive line |
| lp_n | output | 1 | Low-power level of the negative line |
| hs_drive_en | output | 1 | High-speed driver enable |
| hs_level | output | 1 | High-speed differential state (1 = HS-1) |
| busy | output | 1 | A sequence is running; new requests are dropped |

## Verification
The bench issues stop requests on both parities of the toggling phase. A design that honoured the stop at once would end on HS-1 or with an odd transition count. It measures every LP step, the HS-0 lead-in and the trailer cycle by cycle, so an off-by-one in the tick timer or a skipped bridge state shows up as a wrong count. Mismatched requests are issued in Stop, in ULPS and mid-sequence. A controller that accepted them would show LP-10 or a driver enable where none belongs. Holding `tick` low catches a timer that counts clock cycles instead of ticks, and the long wake-up checks the Mark-1 length leaving ULPS.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_HS_REQ,
        ST_HS_BRIDGE,
        ST_HS_LEAD,
        ST_HS_CLK,
        ST_HS_TRAIL,
        ST_ULPS_REQ,
        ST_ULPS,
        ST_WAKE
    } lane_state_t;

    // LP line pair, positive line first
    typedef struct packed {
        logic p;
        logic n;
    } lp_pair_t;

    localparam lp_pair_t LP_11 = '{p: 1'b1, n: 1'b1};
    localparam lp_pair_t LP_01 = '{p: 1'b0, n: 1'b1};
    localparam lp_pair_t LP_10 = '{p: 1'b1, n: 1'b0};
    localparam lp_pair_t LP_00 = '{p: 1'b0, n: 1'b0};

    function automatic logic is_hs_state(lane_state_t s);
        return (s == ST_HS_LEAD) || (s == ST_HS_CLK) || (s == ST_HS_TRAIL);
    endfunction

endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // Without a tick and without a reload the count must not move
    assert_hold_without_tick_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q)
    );

endmodule

// File: rtl/clk_lane_hs_gen.sv
module clk_lane_hs_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stop_req,
    output logic hs_level,
    output logic stop_held,
    output logic hs_end
);

    logic level_q;
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            held_q  <= 1'b0;
        end else if (!run) begin
            level_q <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            level_q <= ~level_q;
            if (stop_req) begin
                held_q <= 1'b1;
            end
        end
    end

    assign hs_level  = level_q;
    assign stop_held = held_q;
    // Leave only while HS-1 is on the lane: the next edge drops it to HS-0
    assign hs_end    = run && held_q && level_q;

    // Transition parity since reset, used by the burst checks
    logic prev_q;
    logic par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            prev_q <= level_q;
            par_q  <= par_q ^ (level_q != prev_q);
        end
    end

    assert_burst_ends_low_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(run) |-> (level_q == 1'b0)
    );

    assert_even_transitions_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(run) |=> (par_q == 1'b0)
    );

endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
    import clk_lane_pkg::*;
#(
    parameter int W          = 10,
    parameter int STEP_TICKS = 2,
    parameter int LEAD_TICKS = 4,
    parameter int TRAIL_TICKS = 4,
    parameter int WAKE_TICKS = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         ulps_req,
    input  logic         wake_req,
    input  logic         tmr_zero,
    input  logic         hs_end,
    input  logic         stop_held,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         clk_run,
    output logic         lp_p,
    output logic         lp_n,
    output logic         hs_drive_en,
    output logic         busy
);

    localparam logic [W-1:0] STEP_V  = W'(STEP_TICKS);
    localparam logic [W-1:0] LEAD_V  = W'(LEAD_TICKS);
    localparam logic [W-1:0] TRAIL_V = W'(TRAIL_TICKS);
    localparam logic [W-1:0] WAKE_V  = W'(WAKE_TICKS);

    lane_state_t state_q;
    lane_state_t state_nx;

    // Next state and timer reload
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_STOP: begin
                if (start_req) begin
                    state_nx = ST_HS_REQ;
                    tmr_load = 1'b1;
                    tmr_val  = STEP_V;
                end else if (ulps_req) begin
                    state_nx = ST_ULPS_REQ;
                    tmr_load = 1'b1;
                    tmr_val  = STEP_V;
                end
            end
            ST_HS_REQ: begin
                if (tmr_zero) begin
                    state_nx = ST_HS_BRIDGE;
                    tmr_load = 1'b1;
                    tmr_val  = STEP_V;
                end
            end
            ST_HS_BRIDGE: begin
                if (tmr_zero) begin
                    state_nx = ST_HS_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = LEAD_V;
                end
            end
            ST_HS_LEAD: begin
                if (tmr_zero) begin
                    state_nx = ST_HS_CLK;
                end
            end
            ST_HS_CLK: begin
                if (hs_end) begin
                    state_nx = ST_HS_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = TRAIL_V;
                end
            end
            ST_HS_TRAIL: begin
                if (tmr_zero) begin
                    state_nx = ST_STOP;
                end
            end
            ST_ULPS_REQ: begin
                if (tmr_zero) begin
                    state_nx = ST_ULPS;
                end
            end
            ST_ULPS: begin
                if (wake_req) begin
                    state_nx = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_V;
                end
            end
            ST_WAKE: begin
                if (tmr_zero) begin
                    state_nx = ST_STOP;
                end
            end
            default: state_nx = ST_STOP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_nx;
        end
    end

    // Outputs
    lp_pair_t lp_w;

    always_comb begin
        lp_w        = LP_11;
        hs_drive_en = 1'b0;
        clk_run     = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_STOP:      busy = 1'b0;
            ST_HS_REQ:    lp_w = LP_01;
            ST_HS_BRIDGE: lp_w = LP_00;
            ST_HS_LEAD: begin
                lp_w        = LP_00;
                hs_drive_en = 1'b1;
            end
            ST_HS_CLK: begin
                lp_w        = LP_00;
                hs_drive_en = 1'b1;
                clk_run     = 1'b1;
                busy        = stop_held;
            end
            ST_HS_TRAIL: begin
                lp_w        = LP_00;
                hs_drive_en = 1'b1;
            end
            ST_ULPS_REQ:  lp_w = LP_10;
            ST_ULPS: begin
                lp_w = LP_00;
                busy = 1'b0;
            end
            ST_WAKE:      lp_w = LP_10;
            default:      lp_w = LP_11;
        endcase
    end

    assign lp_p = lp_w.p;
    assign lp_n = lp_w.n;

    // HS driver never fights a driven LP line
    assert_lp_quiet_in_hs_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        hs_drive_en |-> (!lp_p && !lp_n)
    );

    // Space state is reached only through Mark-1
    assert_ulps_via_mark_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_ULPS && $past(state_q) != ST_ULPS)
            |-> ($past(state_q) == ST_ULPS_REQ)
    );

    // Wake-up always ends in Stop
    assert_wake_to_stop_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_WAKE && state_q != ST_WAKE) |-> (state_q == ST_STOP)
    );

    // An HS state is entered only from the LP-00 bridge or a neighbouring HS state
    assert_hs_entry_path_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(hs_drive_en) |-> ($past(state_q) == ST_HS_BRIDGE)
    );

endmodule

// File: rtl/clk_lane_ctrl.sv
module clk_lane_ctrl #(
    parameter int LP_STEP_TICKS = 2,
    parameter int LEAD_TICKS    = 4,
    parameter int TRAIL_TICKS   = 4,
    parameter int WAKE_TICKS    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_req,
    input  logic stop_req,
    input  logic ulps_req,
    input  logic wake_req,
    output logic lp_p,
    output logic lp_n,
    output logic hs_drive_en,
    output logic hs_level,
    output logic busy
);

    localparam int MAX_A = (LP_STEP_TICKS > LEAD_TICKS)  ? LP_STEP_TICKS : LEAD_TICKS;
    localparam int MAX_B = (TRAIL_TICKS   > WAKE_TICKS)  ? TRAIL_TICKS   : WAKE_TICKS;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAX_T + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          clk_run;
    logic          stop_held;
    logic          hs_end;

    clk_lane_fsm #(
        .W          (TW),
        .STEP_TICKS (LP_STEP_TICKS),
        .LEAD_TICKS (LEAD_TICKS),
        .TRAIL_TICKS(TRAIL_TICKS),
        .WAKE_TICKS (WAKE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .ulps_req   (ulps_req),
        .wake_req   (wake_req),
        .tmr_zero   (tmr_zero),
        .hs_end     (hs_end),
        .stop_held  (stop_held),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .clk_run    (clk_run),
        .lp_p       (lp_p),
        .lp_n       (lp_n),
        .hs_drive_en(hs_drive_en),
        .busy       (busy)
    );

    clk_lane_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (tick),
        .zero    (tmr_zero)
    );

    clk_lane_hs_gen u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (clk_run),
        .stop_req (stop_req),
        .hs_level (hs_level),
        .stop_held(stop_held),
        .hs_end   (hs_end)
    );

    // Driver may only be released while the lane sits at HS-0
    assert_release_on_hs0_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(hs_drive_en) |-> ($past(hs_level) == 1'b0)
    );

endmodule

// File: tb/clk_lane_ctrl_tb.sv
module clk_lane_ctrl_tb;

    localparam int STEP  = 2;
    localparam int LEAD  = 4;
    localparam int TRAIL = 4;
    localparam int WAKE  = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic start_req = 1'b0;
    logic stop_req = 1'b0;
    logic ulps_req = 1'b0;
    logic wake_req = 1'b0;
    logic lp_p, lp_n, hs_drive_en, hs_level, busy;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    clk_lane_ctrl #(
        .LP_STEP_TICKS(STEP),
        .LEAD_TICKS   (LEAD),
        .TRAIL_TICKS  (TRAIL),
        .WAKE_TICKS   (WAKE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_req(start_req), .stop_req(stop_req),
        .ulps_req(ulps_req), .wake_req(wake_req),
        .lp_p(lp_p), .lp_n(lp_n), .hs_drive_en(hs_drive_en),
        .hs_level(hs_level), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] pat();
        return {lp_p, lp_n, hs_drive_en};
    endfunction

    // Count consecutive negedge samples matching p (current sample included)
    task automatic count_pat(input logic [2:0] p, output int c);
        c = 0;
        while (pat() == p && c < 5000) begin
            c++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic t_reset();
        chk(lp_p && lp_n, "R1", "reset lines 11", {lp_p, lp_n}, 3);
        chk(!hs_drive_en && !hs_level, "R1", "reset HS off", {hs_drive_en, hs_level}, 0);
        chk(!busy, "R1", "reset busy", busy, 0);
    endtask

    task automatic t_burst(input int stop_at);
        int c, i, lead, trail, trans;
        logic prev, seen_one, idle_busy_ok;
        pulse(start_req);
        chk(busy == 1'b1, "R9", "busy in LP-01", busy, 1);
        count_pat(3'b010, c);
        chk(c == STEP + 1, "R2", "LP-01 cycles", c, STEP + 1);
        count_pat(3'b000, c);
        chk(c == STEP + 1, "R2", "LP-00 bridge cycles", c, STEP + 1);
        chk(hs_drive_en && !lp_p && !lp_n, "R2", "HS driver on, LP 00", pat(), 1);
        i = 0; lead = 0; trail = 0; trans = 0; prev = 1'b0;
        seen_one = 1'b0; idle_busy_ok = 1'b1;
        while (hs_drive_en && i < 5000) begin
            if (hs_level != prev) trans++;
            if (hs_level) begin
                seen_one = 1'b1;
                trail = 0;
            end else begin
                trail++;
                if (!seen_one) lead++;
            end
            if (seen_one && i < stop_at && busy) idle_busy_ok = 1'b0;
            prev = hs_level;
            stop_req = (i == stop_at);
            i++;
            @(negedge clk);
        end
        stop_req = 1'b0;
        chk(lead == LEAD + 2, "R3", "HS-0 lead cycles", lead, LEAD + 2);
        chk(trans > 0 && trans % 2 == 0, "R4", "even transitions", trans, trans + (trans % 2));
        chk(prev == 1'b0, "R4", "last HS level", prev, 0);
        chk(trail == TRAIL + 1, "R5", "HS-0 trail cycles", trail, TRAIL + 1);
        chk(lp_p && lp_n && !hs_drive_en, "R5", "back to LP-11", pat(), 3'b110);
        chk(idle_busy_ok, "R9", "busy low while toggling", idle_busy_ok, 1);
        chk(!busy, "R9", "busy low in Stop", busy, 0);
    endtask

    task automatic t_ignore_in_stop();
        logic ok = 1'b1;
        pulse(wake_req);
        pulse(stop_req);
        for (int k = 0; k < 10; k++) begin
            if (pat() != 3'b110) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R8", "wake/stop ignored in Stop", pat(), 3'b110);
    endtask

    task automatic t_ignore_mid_seq();
        logic saw_mark = 1'b0;
        int c;
        pulse(start_req);
        pulse(ulps_req);
        pulse(start_req);
        c = 0;
        while (!hs_drive_en && c < 50) begin
            if (lp_p && !lp_n) saw_mark = 1'b1;
            c++;
            @(negedge clk);
        end
        chk(!saw_mark && hs_drive_en, "R8", "ulps/start ignored mid entry", saw_mark, 0);
        // finish the burst
        for (int k = 0; k < 12; k++) @(negedge clk);
        pulse(stop_req);
        c = 0;
        while (hs_drive_en && c < 50) begin c++; @(negedge clk); end
        chk(pat() == 3'b110, "R5", "burst closes after ignored requests", pat(), 3'b110);
    endtask

    task automatic t_ulps_wake();
        int c;
        logic ok = 1'b1;
        pulse(ulps_req);
        count_pat(3'b100, c);
        chk(c == STEP + 1, "R6", "Mark-1 entry cycles", c, STEP + 1);
        for (int k = 0; k < 40; k++) begin
            if (pat() != 3'b000) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R6", "ULPS held at LP-00", pat(), 0);
        chk(!busy, "R9", "busy low in ULPS", busy, 0);
        pulse(start_req);
        pulse(ulps_req);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            if (pat() != 3'b000) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R8", "start/ulps ignored in ULPS", pat(), 0);
        pulse(wake_req);
        chk(busy, "R9", "busy during wake", busy, 1);
        count_pat(3'b100, c);
        chk(c == WAKE + 1, "R7", "wake Mark-1 cycles", c, WAKE + 1);
        chk(pat() == 3'b110, "R7", "Stop after wake", pat(), 3'b110);
    endtask

    task automatic t_tick_gate();
        logic ok = 1'b1;
        int c;
        tick = 1'b0;
        pulse(start_req);
        for (int k = 0; k < 20; k++) begin
            if (pat() != 3'b010) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R10", "LP-01 frozen without tick", pat(), 3'b010);
        tick = 1'b1;
        c = 0;
        while (!hs_drive_en && c < 50) begin c++; @(negedge clk); end
        chk(hs_drive_en, "R10", "advances once tick returns", hs_drive_en, 1);
        for (int k = 0; k < 10; k++) @(negedge clk);
        pulse(stop_req);
        c = 0;
        while (hs_drive_en && c < 50) begin c++; @(negedge clk); end
        chk(pat() == 3'b110, "R10", "Stop after gated burst", pat(), 3'b110);
    endtask

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst(8);
        repeat (3) @(negedge clk);
        t_burst(9);
        repeat (3) @(negedge clk);
        t_burst(20);
        t_ignore_in_stop();
        t_ignore_mid_seq();
        t_ulps_wake();
        t_tick_gate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule